// File: doc/BRIEF.md
# SDRAM Power-Up and Deep-Power-Down Sequencer

This block is the controller-side state machine that takes a low-power single-data-rate SDRAM from power-on to a usable state. It first holds the device idle with the clock enable high while the supplies and clock settle. It then issues, in order, a precharge of all banks, a fixed number of auto-refresh commands, a load of the mode register and a load of the extended mode register. Every wait is counted in clock cycles, and each count is derived from a clock-period parameter and a time in nanoseconds. When the last register load has settled, the block raises a ready flag.

While the block is ready, a request can put the memory into its deepest sleep state. The block precharges every bank, waits the precharge time, and then issues the sleep command on the same edge where the clock enable falls. The memory keeps no data in that state. A wake request therefore raises the clock enable and repeats the whole start-up sequence with the same timing as after power-on. Normal read and write traffic and periodic refresh are handled elsewhere, so this block drives no data pins.

Top module: `sdram_pwr_seq`

## Requirements
- R1: After reset release, the block drives the clock enable high, a no-operation command (chip select low; row strobe, column strobe and write enable high) and ready low for exactly STABLE_CYC cycles. The cycle visible during reset counts as the first of these. STABLE_CYC = ceil(STABLE_NS*1000/CLK_PERIOD_PS), and the first real command appears in cycle STABLE_CYC.
- R2: The first command is a precharge of all banks: chip select, row strobe and write enable low, column strobe high, address bit AP_BIT (10) set, all other address bits zero and bank bits 00.
- R3: The first auto refresh follows the precharge by exactly TRP_CYC cycles, where TRP_CYC = max(2, ceil(TRP_NS*1000/CLK_PERIOD_PS)).
- R4: Exactly REF_COUNT auto refreshes are issued (chip select, row and column strobe low, write enable high, clock enable high). Consecutive refreshes are TRC_CYC = max(2, ceil(TRC_NS*1000/CLK_PERIOD_PS)) cycles apart, and the last one is followed TRC_CYC cycles later by the mode load.
- R5: The mode load drives all four command pins low with bank bits 00 and the address equal to MODE_OP. The extended load follows max(2, MRD_CYC) cycles later, with the same command pins, bank bits 10 (ba[1]=1, ba[0]=0) and the address equal to EXT_OP.
- R6: Ready rises exactly max(2, MRD_CYC) cycles after the extended load. It stays high, with a no-operation command and the clock enable high, until a sleep request is taken.
- R7: In every cycle without a scheduled command while the clock enable is high, the pins carry the no-operation code with address and bank bits zero.
- R8: A sleep request sampled while ready causes a precharge of all banks in the next cycle, with ready low. TRP_CYC cycles after that precharge, the sleep command appears (chip select and write enable low, row and column strobe high) with the clock enable low in that same cycle.
- R9: The clock enable stays low until a wake request is sampled. In the next cycle the clock enable is high, and the sequence of R1 to R6 repeats with the same cycle counts, counted from that cycle.
- R10: A sleep request is ignored outside the ready state, and a wake request is ignored outside the sleep state. In either case the command sequence and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; starts the power-on sequence |
| dpd_req | input | 1 | Request to enter deep sleep, taken only while ready |
| wake_req | input | 1 | Request to leave deep sleep, taken only while asleep |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address bits |
| addr | output | ROW_W | Address bus (opcodes, precharge-all flag) |
| ready | output | 1 | High once initialization has finished |

## Verification
The hardest situations to reach from the ports are the repeated re-initialization after a wake, and requests that arrive in the wrong state. A single power-on run shows neither. The stimulus runs one power-on sequence and then several sleep and wake rounds. Each round changes how long ready is held before the sleep request and how long the device sleeps. On alternate rounds, sleep requests are held high throughout the settle wait and wake requests are held high while ready. Every cycle of every re-initialization is compared with the expected command stream, so an ignored request that wrongly takes effect shows up as a shifted or extra command.

// File: rtl/pwr_seq_pkg.sv
// Package: shared state and command types plus the time-to-cycle helper
// used by the SDRAM power sequencer. Assumes times in ns and periods in ps.
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_STABLE,
        ST_PREA,
        ST_PREA_W,
        ST_REF,
        ST_REF_W,
        ST_MRS,
        ST_MRS_W,
        ST_EMRS,
        ST_EMRS_W,
        ST_READY,
        ST_DPD_PRE,
        ST_DPD_PRE_W,
        ST_DPD_ENTER,
        ST_DPD
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PREA,
        CMD_REF,
        CMD_MRS,
        CMD_EMRS,
        CMD_DPD
    } seq_cmd_t;

    // Round a time in ns up to whole clock cycles, never below floor_cyc.
    function automatic int ns_to_cyc(input int ns, input int period_ps, input int floor_cyc);
        int v;
        v = (ns * 1000 + period_ps - 1) / period_ps;
        return (v < floor_cyc) ? floor_cyc : v;
    endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
// Module: loadable down counter that times the gap between commands.
// It reports done in the last cycle of a wait, when the count is 1.
// Assumes every load value is at least 1. The reset value starts the
// power-on settle wait.
module pwr_seq_timer #(
    parameter int            CW      = 16,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    // Load on command, else count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Final cycle of the wait.
    assign done = (cnt == CW'(1));

    AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R3

endmodule

// File: rtl/pwr_seq_refcnt.sv
// Module: counts the auto-refresh commands issued in one initialization
// pass. It is cleared at the start of each pass and raises last once
// REF_COUNT refreshes have gone out.
module pwr_seq_refcnt #(
    parameter int REF_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int RW = $clog2(REF_COUNT + 1);

    logic [RW-1:0] cnt;

    // Track the refreshes issued since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // All required refreshes have been issued.
    assign last = (cnt == RW'(REF_COUNT));

    AST_REF_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last); // R4

endmodule

// File: rtl/pwr_seq_pins.sv
// Module: turns the abstract command and the sleep flag into SDRAM pin
// levels. Purely combinational. Assumes ROW_W > AP_BIT.
module pwr_seq_pins
    import pwr_seq_pkg::*;
#(
    parameter int               ROW_W   = 13,
    parameter int               AP_BIT  = 10,
    parameter logic [ROW_W-1:0] MODE_OP = '0,
    parameter logic [ROW_W-1:0] EXT_OP  = '0
) (
    input  seq_cmd_t         cmd,
    input  logic             sleep,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr
);

    // Encode the command onto chip select, strobes, bank and address.
    always_comb begin
        cke   = !sleep;
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = 2'b00;
        addr  = '0;
        case (cmd)
            CMD_PREA: begin
                ras_n        = 1'b0;
                we_n         = 1'b0;
                addr[AP_BIT] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = MODE_OP;
            end
            CMD_EMRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = 2'b10;
                addr  = EXT_OP;
            end
            CMD_DPD: begin
                we_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdram_pwr_seq.sv
// Module: SDRAM initialization and deep-sleep sequencer (top).
// Runs settle wait, precharge-all, REF_COUNT refreshes, mode load and
// extended load, then flags ready. It enters deep sleep on request and
// repeats the full sequence after a wake. Every gap is counted in cycles
// derived from CLK_PERIOD_PS. Assumes the clock runs from reset onward.
module sdram_pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int               CLK_PERIOD_PS = 7500,
    parameter int               STABLE_NS     = 200000,
    parameter int               TRP_NS        = 19,
    parameter int               TRC_NS        = 65,
    parameter int               MRD_CYC       = 2,
    parameter int               REF_COUNT     = 8,
    parameter int               ROW_W         = 13,
    parameter int               AP_BIT        = 10,
    parameter logic [ROW_W-1:0] MODE_OP       = ROW_W'('h032),
    parameter logic [ROW_W-1:0] EXT_OP        = ROW_W'('h000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dpd_req,
    input  logic             wake_req,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr,
    output logic             ready
);

    localparam int STABLE_CYC = ns_to_cyc(STABLE_NS, CLK_PERIOD_PS, 2);
    localparam int TRP_CYC    = ns_to_cyc(TRP_NS, CLK_PERIOD_PS, 2);
    localparam int TRC_CYC    = ns_to_cyc(TRC_NS, CLK_PERIOD_PS, 2);
    localparam int MRD_GAP    = (MRD_CYC < 2) ? 2 : MRD_CYC;
    localparam int GAP_A      = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int GAP_B      = (GAP_A > MRD_GAP) ? GAP_A : MRD_GAP;
    localparam int MAX_CYC    = (GAP_B > STABLE_CYC) ? GAP_B : STABLE_CYC;
    localparam int CW         = $clog2(MAX_CYC + 1);

    seq_state_t    state, nxt;
    seq_cmd_t      cmd;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          ref_clr;
    logic          ref_inc;
    logic          ref_last;
    logic          sleep;

    // Gap timer shared by every wait in the sequence.
    pwr_seq_timer #(
        .CW      (CW),
        .RST_VAL (CW'(STABLE_CYC))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Counter of refreshes within one initialization pass.
    pwr_seq_refcnt #(
        .REF_COUNT (REF_COUNT)
    ) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ref_clr),
        .inc   (ref_inc),
        .last  (ref_last)
    );

    // Pin encoder for the command chosen this cycle.
    pwr_seq_pins #(
        .ROW_W   (ROW_W),
        .AP_BIT  (AP_BIT),
        .MODE_OP (MODE_OP),
        .EXT_OP  (EXT_OP)
    ) u_pins (
        .cmd   (cmd),
        .sleep (sleep),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

    // Sequencer state register; reset starts the power-on settle wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STABLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state, command, timer loads and refresh bookkeeping.
    always_comb begin
        nxt      = state;
        cmd      = CMD_NOP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_clr  = 1'b0;
        ref_inc  = 1'b0;
        case (state)
            ST_STABLE: begin
                if (tmr_done) nxt = ST_PREA;
            end
            ST_PREA: begin
                cmd      = CMD_PREA;
                tmr_load = 1'b1;
                tmr_val  = CW'(TRP_CYC - 1);
                ref_clr  = 1'b1;
                nxt      = ST_PREA_W;
            end
            ST_PREA_W: begin
                if (tmr_done) nxt = ST_REF;
            end
            ST_REF: begin
                cmd      = CMD_REF;
                tmr_load = 1'b1;
                tmr_val  = CW'(TRC_CYC - 1);
                ref_inc  = 1'b1;
                nxt      = ST_REF_W;
            end
            ST_REF_W: begin
                if (tmr_done) nxt = ref_last ? ST_MRS : ST_REF;
            end
            ST_MRS: begin
                cmd      = CMD_MRS;
                tmr_load = 1'b1;
                tmr_val  = CW'(MRD_GAP - 1);
                nxt      = ST_MRS_W;
            end
            ST_MRS_W: begin
                if (tmr_done) nxt = ST_EMRS;
            end
            ST_EMRS: begin
                cmd      = CMD_EMRS;
                tmr_load = 1'b1;
                tmr_val  = CW'(MRD_GAP - 1);
                nxt      = ST_EMRS_W;
            end
            ST_EMRS_W: begin
                if (tmr_done) nxt = ST_READY;
            end
            ST_READY: begin
                if (dpd_req) nxt = ST_DPD_PRE;
            end
            ST_DPD_PRE: begin
                cmd      = CMD_PREA;
                tmr_load = 1'b1;
                tmr_val  = CW'(TRP_CYC - 1);
                nxt      = ST_DPD_PRE_W;
            end
            ST_DPD_PRE_W: begin
                if (tmr_done) nxt = ST_DPD_ENTER;
            end
            ST_DPD_ENTER: begin
                cmd = CMD_DPD;
                nxt = ST_DPD;
            end
            ST_DPD: begin
                if (wake_req) begin
                    tmr_load = 1'b1;
                    tmr_val  = CW'(STABLE_CYC);
                    nxt      = ST_STABLE;
                end
            end
            default: nxt = ST_STABLE;
        endcase
    end

    // Clock enable is low from the sleep command until the wake.
    assign sleep = (state == ST_DPD_ENTER) || (state == ST_DPD);
    assign ready = (state == ST_READY);

    AST_DPD_ENTRY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!cs_n && ras_n && cas_n && !we_n)); // R8
    AST_DPD_AFTER_PREA: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DPD) |-> ($past(state) == ST_DPD_PRE_W)); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cke && !cs_n && ras_n && cas_n && we_n)); // R6
    AST_REG_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n) |=> (!cs_n && ras_n && cas_n && we_n)); // R5
    AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(state) == ST_EMRS_W)); // R6
    AST_WAKE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!cs_n && ras_n && cas_n && we_n)); // R9

endmodule

// File: tb/sdram_pwr_seq_test.sv
// Bench: power-on sequence, then several sleep/wake rounds with varied hold
// and dwell times and with ignored requests, checked cycle by cycle.
module sdram_pwr_seq_test;

    localparam int PER_PS    = 8000;
    localparam int STABLE_NS = 300;
    localparam int TRP_NS    = 19;
    localparam int TRC_NS    = 65;
    localparam int MRD       = 2;
    localparam int NREF      = 8;
    localparam int ROW_W     = 13;
    localparam logic [ROW_W-1:0] MODE_V = 13'h0232;
    localparam logic [ROW_W-1:0] EXT_V  = 13'h0061;

    localparam int RAW_ST  = (STABLE_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int RAW_RP  = (TRP_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int RAW_RC  = (TRC_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int E_ST    = (RAW_ST < 2) ? 2 : RAW_ST;
    localparam int E_RP    = (RAW_RP < 2) ? 2 : RAW_RP;
    localparam int E_RC    = (RAW_RC < 2) ? 2 : RAW_RC;
    localparam int E_MRD   = (MRD < 2) ? 2 : MRD;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             dpd_req;
    logic             wake_req;
    logic             cke, cs_n, ras_n, cas_n, we_n, ready;
    logic [1:0]       ba;
    logic [ROW_W-1:0] addr;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sdram_pwr_seq #(
        .CLK_PERIOD_PS (PER_PS),
        .STABLE_NS     (STABLE_NS),
        .TRP_NS        (TRP_NS),
        .TRC_NS        (TRC_NS),
        .MRD_CYC       (MRD),
        .REF_COUNT     (NREF),
        .ROW_W         (ROW_W),
        .AP_BIT        (10),
        .MODE_OP       (MODE_V),
        .EXT_OP        (EXT_V)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dpd_req  (dpd_req),
        .wake_req (wake_req),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr),
        .ready    (ready)
    );

    // Command codes: 0 nop, 1 precharge-all, 2 refresh, 3 mode, 4 ext, 5 sleep, 6 other
    function automatic int code();
        case ({cs_n, ras_n, cas_n, we_n})
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return (ba == 2'b10) ? 4 : 3;
            4'b0110: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_cmd(input int exp, input string req);
        chk(code() == exp, req, "command", code(), exp);
    endtask

    // Idle cycles: NOP, zero address/bank, clock enable high, given ready.
    task automatic nops(input int n, input string req, input bit rdy);
        for (int i = 0; i < n; i++) begin
            expect_cmd(0, req);
            chk(addr == '0 && ba == 2'b00, "R7", "idle addr/bank", int'({ba, addr}), 0);
            chk(cke == 1'b1 && ready == rdy, req, "cke/ready", int'({cke, ready}), int'({1'b1, rdy}));
            step();
        end
    endtask

    // Full initialization from its first settle cycle up to ready.
    task automatic run_init(input bit noise);
        for (int i = 0; i < E_ST; i++) begin
            expect_cmd(0, "R1");
            chk(cke == 1'b1 && ready == 1'b0, "R1", "cke/ready settle", int'({cke, ready}), 2);
            dpd_req = noise;                        // R10 sleep request ignored here
            step();
        end
        dpd_req = 1'b0;
        expect_cmd(1, "R2");
        chk(addr == 13'h0400 && ba == 2'b00, "R2", "precharge addr", int'({ba, addr}), 'h400);
        step();
        nops(E_RP - 1, "R3", 1'b0);
        for (int r = 0; r < NREF; r++) begin
            expect_cmd(2, "R4");
            chk(cke == 1'b1, "R4", "refresh cke", int'(cke), 1);
            step();
            nops(E_RC - 1, "R4", 1'b0);
        end
        expect_cmd(3, "R5");
        chk(addr == MODE_V && ba == 2'b00, "R5", "mode load", int'({ba, addr}), int'(MODE_V));
        step();
        nops(E_MRD - 1, "R5", 1'b0);
        expect_cmd(4, "R5");
        chk(addr == EXT_V && ba == 2'b10, "R5", "ext load", int'({ba, addr}), int'({2'b10, EXT_V}));
        step();
        nops(E_MRD - 1, "R6", 1'b0);
        chk(ready == 1'b1, "R6", "ready", int'(ready), 1);
    endtask

    // Sleep round: hold ready, request sleep, dwell, wake, re-initialize.
    task automatic sleep_round(input int hold, input int dwell, input bit noise);
        for (int i = 0; i < hold; i++) begin
            chk(ready == 1'b1 && code() == 0 && cke == 1'b1, "R6", "ready hold",
                int'({ready, cke}), 3);
            wake_req = noise;                       // R10 wake request ignored here
            step();
        end
        wake_req = 1'b0;
        dpd_req  = 1'b1;
        step();
        dpd_req  = 1'b0;
        expect_cmd(1, "R8");
        chk(ready == 1'b0, "R8", "ready drop", int'(ready), 0);
        step();
        nops(E_RP - 1, "R8", 1'b0);
        expect_cmd(5, "R8");
        chk(cke == 1'b0, "R8", "cke at sleep cmd", int'(cke), 0);
        step();
        for (int i = 0; i < dwell; i++) begin
            chk(cke == 1'b0, "R9", "cke asleep", int'(cke), 0);
            dpd_req = noise;
            step();
        end
        dpd_req  = 1'b0;
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk(cke == 1'b1, "R9", "cke after wake", int'(cke), 1);
        run_init(!noise);
    endtask

    initial begin
        rst_n    = 1'b0;
        dpd_req  = 1'b0;
        wake_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(cke == 1'b1 && ready == 1'b0 && code() == 0, "R1", "reset state",
            int'({cke, ready}), 2);
        @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        run_init(1'b0);
        for (int h = 0; h < 5; h++) begin
            sleep_round(h, 2 * h + 1, h[0]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1: actual=%0d expected=%0d", 20000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule